// File: doc/BRIEF.md
# Accumulator Adder with Status Flags

This block holds the 8-bit accumulator of a small accumulator machine, the adder that updates it, and the 8-bit status byte that records the result flags of each addition. An addition takes an operand from the input port and adds it to the accumulator. Plain add uses a carry-in of zero. Add-with-carry feeds in the current carry flag. The addition sets three flags: carry out of bit 7, half carry out of bit 3, and signed overflow.

The status byte can also be written as a whole by software. It holds two user flags that arithmetic never changes, and two register-bank select bits that are exported to the register file. The parity bit is not stored. It is always derived from the accumulator, so a status write cannot change it. The accumulator can also be loaded directly from the operand port.

Top module: `acc_adder_psw`

## Requirements
- R1: After reset the accumulator reads 0x00 and the status byte reads 0x00.
- R2: When `add_en` is high and `acc_we` is low, the accumulator becomes (acc + opnd + cin) mod 256 on the next clock. cin is status bit 7 when `add_cy` is high, and 0 when `add_cy` is low.
- R3: After such an addition, status bit 7 (carry) holds the carry out of bit 7 of the sum.
- R4: After such an addition, status bit 6 (half carry) holds the carry out of bit 3 into bit 4.
- R5: After such an addition, status bit 2 (overflow) is 1 exactly when both addends have the same sign bit and the result's sign bit differs from it.
- R6: Status bit 0 always equals the XOR of the eight accumulator bits. A status write cannot set or clear it.
- R7: When `psw_we` is high and no addition takes effect, status bits 7..1 take `psw_wdata[7:1]` on the next clock.
- R8: When `psw_we` and an effective addition coincide, bits 7, 6 and 2 come from the addition. Bits 5, 4, 3 and 1 come from `psw_wdata`.
- R9: Status bits 5 (user flag 0), 4 and 3 (bank select) and 1 (user flag 1) change only through `psw_we`. Additions never change them.
- R10: `bank` always equals {status bit 4, status bit 3}.
- R11: When `acc_we` is high, the accumulator loads `opnd` on the next clock, even if `add_en` is also high. In that case the addition is discarded and does not change bits 7, 6 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd | input | 8 | Addend, or load value for the accumulator |
| add_en | input | 1 | Perform an addition this cycle |
| add_cy | input | 1 | Use the carry flag as carry-in for the addition |
| psw_we | input | 1 | Write the status byte |
| psw_wdata | input | 8 | Status write data (bit 0 ignored) |
| acc_we | input | 1 | Load `opnd` into the accumulator |
| acc | output | 8 | Accumulator |
| psw | output | 8 | Status byte: C, AC, F0, RS1, RS0, OV, UD, P from bit 7 down |
| bank | output | 2 | Register bank select {RS1, RS0} |

## Verification
The properties assume that every input is a known 0 or 1 at each rising edge. They also assume reset has been held for at least one edge before any check starts. With that in place, the previous cycle's port values fully determine the flag and sum results.

The stimulus changes inputs only on falling edges. It releases reset before any operation, and it never leaves an input undriven. The exhaustive sweep loads every accumulator value, sets the carry flag through the status port in the same cycle, and then adds a range of operands. This keeps every flag check within those assumptions.

// File: rtl/acc_adder_psw.sv
module acc_adder_psw (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] opnd,
  input  logic       add_en,
  input  logic       add_cy,
  input  logic       psw_we,
  input  logic [7:0] psw_wdata,
  input  logic       acc_we,
  output logic [7:0] acc,
  output logic [7:0] psw,
  output logic [1:0] bank
);
  localparam int BitC  = 7;
  localparam int BitAc = 6;
  localparam int BitOv = 2;

  logic [7:0] acc_q;
  logic [7:1] st_q, st_d;

  logic       cin;
  logic [4:0] lo;
  logic [3:0] hi;
  logic [1:0] top;
  logic [7:0] sum;
  logic       do_add;

  assign cin    = add_cy & st_q[BitC];
  assign lo     = {1'b0, acc_q[3:0]} + {1'b0, opnd[3:0]} + {4'd0, cin};
  assign hi     = {1'b0, acc_q[6:4]} + {1'b0, opnd[6:4]} + {3'd0, lo[4]};
  assign top    = {1'b0, acc_q[7]} + {1'b0, opnd[7]} + {1'b0, hi[3]};
  assign sum    = {top[0], hi[2:0], lo[3:0]};
  assign do_add = add_en & ~acc_we;

  always_comb begin
    st_d = st_q;
    if (psw_we) st_d = psw_wdata[7:1];
    if (do_add) begin
      st_d[BitC]  = top[1];
      st_d[BitAc] = lo[4];
      st_d[BitOv] = top[1] ^ hi[3];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      st_q  <= '0;
    end else begin
      st_q <= st_d;
      if (acc_we)      acc_q <= opnd;
      else if (do_add) acc_q <= sum;
    end
  end

  assign acc  = acc_q;
  assign psw  = {st_q, ^acc_q};
  assign bank = st_q[4:3];
endmodule

// File: rtl/acc_adder_psw_chk.sv
module acc_adder_psw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] opnd,
  input logic       add_en,
  input logic       add_cy,
  input logic       psw_we,
  input logic       acc_we,
  input logic [7:0] acc,
  input logic [7:0] psw
);
  logic       eff_add;
  logic       ci;
  logic [8:0] wide;
  assign eff_add = add_en & ~acc_we;
  assign ci      = add_cy & psw[7];
  assign wide    = {1'b0, acc} + {1'b0, opnd} + {8'd0, ci};

  // R2
  sum_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_add |=> acc == $past(wide[7:0]));

  // R3
  carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_add |=> psw[7] == $past(wide[8]));

  // R5
  signed_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eff_add |=> psw[2] == (($past(acc[7]) == $past(opnd[7])) && (acc[7] != $past(acc[7]))));

  // R9
  user_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !psw_we |=> $stable({psw[5:3], psw[1]}));

  // R11
  acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> acc == $past(opnd));

  // R11
  load_flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && !psw_we) |=> $stable({psw[7:6], psw[2]}));
endmodule

bind acc_adder_psw acc_adder_psw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .opnd(opnd), .add_en(add_en), .add_cy(add_cy),
  .psw_we(psw_we), .acc_we(acc_we), .acc(acc), .psw(psw)
);

// File: tb/acc_adder_psw_test.sv
module acc_adder_psw_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] opnd = '0, psw_wdata = '0;
  logic       add_en = 1'b0, add_cy = 1'b0, psw_we = 1'b0, acc_we = 1'b0;
  logic [7:0] acc, psw;
  logic [1:0] bank;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_acc = '0;
  logic [7:1] m_st = '0;
  bit done = 0;

  always #5 clk = ~clk;

  acc_adder_psw uut (
    .clk(clk), .rst_n(rst_n), .opnd(opnd), .add_en(add_en), .add_cy(add_cy),
    .psw_we(psw_we), .psw_wdata(psw_wdata), .acc_we(acc_we),
    .acc(acc), .psw(psw), .bank(bank)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit ad, input bit cy, input bit pw, input logic [7:0] pwd,
                     input bit aw, input logic [7:0] op);
    int ci, s, a, b, hc, ov;
    bit eff;
    string atag, utag;
    @(negedge clk);
    add_en = ad; add_cy = cy; psw_we = pw; psw_wdata = pwd; acc_we = aw; opnd = op;
    a = m_acc; b = op; ci = (cy && m_st[7]) ? 1 : 0;
    s = a + b + ci;
    hc = ((a % 16) + (b % 16) + ci) / 16;
    ov = (((a ^ s) & (b ^ s) & 128) != 0) ? 1 : 0;
    eff = ad && !aw;
    if (pw) m_st = pwd[7:1];
    if (eff) begin
      m_st[7] = s[8]; m_st[6] = hc[0]; m_st[2] = ov[0];
    end
    if (aw) m_acc = op; else if (eff) m_acc = s[7:0];
    atag = aw ? "R11 acc load" : (eff ? "R2 sum" : "R7 acc hold");
    utag = pw ? (eff ? "R8 user bits" : "R7 user bits") : "R9 user bits";
    @(posedge clk);
    #1;
    chk(atag, acc, m_acc);
    chk(eff ? "R3 carry" : (pw ? "R7 carry" : "R11 carry"), psw[7], m_st[7]);
    chk(eff ? "R4 half carry" : "R7 half carry", psw[6], m_st[6]);
    chk(eff ? "R5 overflow" : "R7 overflow", psw[2], m_st[2]);
    chk("R6 parity", psw[0], ^m_acc);
    chk(utag, {psw[5:3], psw[1]}, {m_st[5:3], m_st[1]});
    chk("R10 bank", bank, m_st[4:3]);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1 acc reset", acc, 0);
    chk("R1 psw reset", psw, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7/R6: status write with bit 0 set must not force parity
    cyc(0, 0, 1, 8'hFF, 0, 8'h00);
    cyc(0, 0, 1, 8'h01, 0, 8'h00);
    // R8: write and add together
    cyc(0, 0, 0, 8'h00, 1, 8'h7F);
    cyc(1, 0, 1, 8'hFE, 0, 8'h01);
    // R11: load beats add, flags kept
    cyc(1, 1, 0, 8'h00, 1, 8'hC3);
    // R9: additions with user and bank bits set
    cyc(0, 0, 1, 8'h3A, 0, 8'h00);
    cyc(1, 1, 0, 8'h00, 0, 8'hF0);
    cyc(1, 1, 0, 8'h00, 0, 8'h9C);

    // R2..R6 sweep: every accumulator value, operands in steps of 3, both carry-in values
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b += 3) begin
        logic [7:0] w;
        w = {b[0], 1'b0, a[1:0] == 2'b11, b[2:1], 2'b00, a[2]};
        cyc(0, 0, 1, w, 1, a[7:0]);
        cyc(1, b[1] | a[0], 0, 8'h00, 0, b[7:0]);
      end
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule